// File: doc/BRIEF.md
# Strided Loop Fetch and Multiply-Accumulate Engine

This block runs one counted inner loop in dedicated hardware beside a small configurable fabric. The loop counter, the exit test and the address stepping live in the block itself, so the fabric needs no state machine for them. Software loads four settings through a configuration write port: a start address, a constant address step, an iteration count and a constant multiplier. It then pulses `start`.

On each iteration the engine issues one read on a simple synchronous memory port and waits for the read-valid flag. It multiplies the returned word by the constant and adds the product into a 32-bit accumulator. It then steps the address. When the count is used up, the engine raises `done`, and `result` holds the sum.

A loop such as `sum += a[i]*2` maps onto the engine directly. The memory base is the address of `a`, the step is one word, and the multiplier is 2.

Top module: `loop_mac_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_rd` are 0 and `result` is 0.
- R2: The k-th read of a run (k counted from 0) presents `mem_addr` = (start address + k × step) modulo 2^AW. The first read is issued in the cycle after the start edge.
- R3: A run with a nonzero count N issues exactly N reads. It then raises `done` and drops `busy`.
- R4: The accumulator is cleared when a run starts. At the end of the run, `result` equals the sum over all reads of (read word × multiplier), taken modulo 2^32.
- R5: A run with count 0 makes no memory read. It sets `done` in the cycle after the start edge, and `result` reads 0.
- R6: The engine accumulates only when `mem_rvalid` is 1. It keeps at most one read outstanding, so any added read latency still gives the R4 result.
- R7: While `busy` is 1, `start` pulses and configuration writes are ignored. The running loop is unaffected, and the stored settings keep their earlier values.
- R8: `done` stays at 1 while the engine is idle, until the next accepted start clears it. `done` and `busy` are never 1 together.
- R9: Configuration select codes are: 0 = start address (low AW bits of `cfg_data`), 1 = step (low AW bits), 2 = iteration count (low CW bits), 3 = multiplier (32 bits). A write takes effect at the clock edge where `cfg_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Setting selected for the write |
| cfg_data | input | 32 | Value written |
| start | input | 1 | Launches a run when idle |
| mem_rd | output | 1 | Read request, one cycle per iteration |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has completed |
| result | output | 32 | Accumulated sum |

## Verification
The bench builds the engine with AW = 8 and CW = 6. With an 8-bit address, a 256-word memory model covers the whole address space, so runs whose addresses wrap past the top of memory are easy to set up. With a 6-bit count, the largest loop of 63 iterations finishes in a short run. The memory model adds a selectable number of wait cycles before `mem_rvalid`, which exercises the wait-for-data path. An all-ones multiplier forces the 32-bit sum to wrap.

// File: rtl/lag_pkg.sv
package lag_pkg;

  localparam int WORD_W = 32;

  localparam logic [1:0] SEL_BASE   = 2'd0;
  localparam logic [1:0] SEL_STRIDE = 2'd1;
  localparam logic [1:0] SEL_COUNT  = 2'd2;
  localparam logic [1:0] SEL_COEF   = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } lag_state_e;

  // address step on a full word; callers truncate to their width
  function automatic logic [31:0] addr_advance(input logic [31:0] cur,
                                               input logic [31:0] step);
    return cur + step;
  endfunction

  // one multiply-accumulate step, wrapping modulo 2^32
  function automatic logic [WORD_W-1:0] mac_step(input logic [WORD_W-1:0] acc,
                                                 input logic [WORD_W-1:0] data,
                                                 input logic [WORD_W-1:0] coef);
    logic [WORD_W-1:0] prod;
    prod = data * coef;
    return acc + prod;
  endfunction

endpackage

// File: rtl/lag_addr_gen.sv
module lag_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_next;

  assign addr_next = AW'(lag_pkg::addr_advance(32'(addr_q), 32'(stride)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= base;
    else if (step) addr_q <= addr_next;
  end

  assign addr = addr_q;

  // a load and a step never fall in the same cycle
  assert_load_step_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step));

endmodule

// File: rtl/lag_loop_ctrl.sv
module lag_loop_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] count_in,
  input  logic          rvalid,
  output logic          start_ok,
  output logic          issue,
  output logic          acc_en,
  output logic          busy,
  output logic          done
);
  import lag_pkg::*;

  lag_state_e    state;
  logic [CW-1:0] remaining;
  logic          done_q;
  logic          zero_count;

  assign zero_count = (count_in == '0);
  assign start_ok   = start && (state == ST_IDLE);
  assign issue      = (state == ST_ISSUE);
  assign acc_en     = (state == ST_WAIT) && rvalid;
  assign busy       = (state != ST_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
      done_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            remaining <= count_in;
            done_q    <= zero_count;
            state     <= zero_count ? ST_IDLE : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          remaining <= remaining - 1'b1;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rvalid) begin
            if (remaining == '0) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // the counter never underflows while a read is being issued
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (remaining != '0));

  // no second read while the first one is still outstanding
  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);

endmodule

// File: rtl/lag_mac.sv
module lag_mac (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [31:0] data,
  input  logic [31:0] coef,
  output logic [31:0] acc
);

  logic [31:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (en)    acc_q <= lag_pkg::mac_step(acc_q, data, coef);
  end

  assign acc = acc_q;

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0));

endmodule

// File: rtl/loop_mac_engine.sv
module loop_mac_engine #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_data,
  input  logic          start,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rvalid,
  output logic          busy,
  output logic          done,
  output logic [31:0]   result
);
  import lag_pkg::*;

  logic [AW-1:0] base_q;
  logic [AW-1:0] stride_q;
  logic [CW-1:0] count_q;
  logic [31:0]   coef_q;

  logic cfg_accept;
  logic start_ok;
  logic issue;
  logic acc_en;

  assign cfg_accept = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
      count_q  <= '0;
      coef_q   <= '0;
    end else if (cfg_accept) begin
      unique case (cfg_sel)
        SEL_BASE:   base_q   <= cfg_data[AW-1:0];
        SEL_STRIDE: stride_q <= cfg_data[AW-1:0];
        SEL_COUNT:  count_q  <= cfg_data[CW-1:0];
        default:    coef_q   <= cfg_data;
      endcase
    end
  end

  lag_loop_ctrl #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .count_in (count_q),
    .rvalid   (mem_rvalid),
    .start_ok (start_ok),
    .issue    (issue),
    .acc_en   (acc_en),
    .busy     (busy),
    .done     (done)
  );

  lag_addr_gen #(.AW(AW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_ok),
    .step   (issue),
    .base   (base_q),
    .stride (stride_q),
    .addr   (mem_addr)
  );

  lag_mac u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_ok),
    .en    (acc_en),
    .data  (mem_rdata),
    .coef  (coef_q),
    .acc   (result)
  );

  assign mem_rd = issue;

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count_q != '0) |=> (mem_rd && mem_addr == $past(base_q)));

  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count_q == '0) |=> (done && !busy && !mem_rd));

  assert_hold_without_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rvalid && !start) |=> $stable(result));

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(base_q) && $stable(stride_q) && $stable(count_q) && $stable(coef_q)));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/loop_mac_engine_test.sv
module loop_mac_engine_test;

  localparam int AW = 8;
  localparam int CW = 6;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [31:0]   cfg_data = '0;
  logic          start = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata = '0;
  logic          mem_rvalid = 1'b0;
  logic          busy;
  logic          done;
  logic [31:0]   result;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  loop_mac_engine #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .start(start), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .busy(busy),
    .done(done), .result(result)
  );

  // memory model with selectable extra latency
  logic [31:0]   mem [MW];
  int            lat_extra = 0;
  logic          pend = 1'b0;
  int            pcnt = 0;
  logic [AW-1:0] paddr = '0;
  int            nreads = 0;
  logic [AW-1:0] addr_log [4096];

  initial for (int i = 0; i < MW; i++) mem[i] = (i * 32'h0101_0103) ^ 32'h5A00_0017;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd) begin
      addr_log[nreads % 4096] <= mem_addr;
      nreads <= nreads + 1;
      if (lat_extra == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr];
      end else begin
        pend  <= 1'b1;
        pcnt  <= lat_extra;
        paddr <= mem_addr;
      end
    end else if (pend) begin
      if (pcnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[paddr];
        pend       <= 1'b0;
      end else begin
        pcnt <= pcnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    ok = done;
  endtask

  function automatic logic [31:0] model_sum(input logic [AW-1:0] b, input logic [AW-1:0] s,
                                            input int cnt, input logic [31:0] k);
    logic [63:0]   acc = 0;
    logic [AW-1:0] a = b;
    for (int i = 0; i < cnt; i++) begin
      acc = acc + {32'd0, mem[a]} * {32'd0, k};
      a = a + s;
    end
    return acc[31:0];
  endfunction

  // full run: program, start, wait, check R2, R3, R4, R8
  task automatic run_loop(input logic [AW-1:0] b, input logic [AW-1:0] s, input int cnt,
                          input logic [31:0] k, input int lat, input string tag);
    int r0; bit ok; logic [AW-1:0] ea;
    lat_extra = lat;
    cfg_write(2'd0, 32'(b));
    cfg_write(2'd1, 32'(s));
    cfg_write(2'd2, 32'(cnt));
    cfg_write(2'd3, k);
    r0 = nreads;
    pulse_start();
    chk(busy == 1'b1, "R8", {tag, " busy after start"}, 32'(busy), 1);
    wait_done(ok);
    chk(ok, "R3", {tag, " done reached"}, 32'(done), 1);
    chk(nreads - r0 == cnt, "R3", {tag, " read count"}, 32'(nreads - r0), 32'(cnt));
    ea = b;
    for (int i = 0; i < cnt; i++) begin
      chk(addr_log[(r0 + i) % 4096] == ea, "R2", {tag, " read address"},
          32'(addr_log[(r0 + i) % 4096]), 32'(ea));
      ea = ea + s;
    end
    chk(result == model_sum(b, s, cnt, k), (lat > 0) ? "R6" : "R4", {tag, " result"},
        result, model_sum(b, s, cnt, k));
    chk(!busy, "R8", {tag, " idle at done"}, 32'(busy), 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && mem_rd == 0, "R1", "control outputs after reset",
        {29'd0, busy, done, mem_rd}, 0);
    chk(result == 0, "R1", "result after reset", result, 0);
  endtask

  task automatic t_zero_count();
    int r0;
    cfg_write(2'd2, 32'd0);
    r0 = nreads;
    pulse_start();
    chk(done == 1 && busy == 0, "R5", "done one cycle after zero-count start",
        {30'd0, done, busy}, 32'b10);
    repeat (3) @(negedge clk);
    chk(nreads == r0, "R5", "no read for zero count", 32'(nreads - r0), 0);
    chk(result == 0, "R5", "result cleared for zero count", result, 0);
  endtask

  task automatic t_done_hold();
    repeat (6) @(negedge clk);
    chk(done == 1 && busy == 0, "R8", "done held while idle", {30'd0, done, busy}, 32'b10);
    cfg_write(2'd2, 32'd2);
    pulse_start();
    chk(done == 0, "R8", "done cleared by new start", 32'(done), 0);
    begin bit ok; wait_done(ok); end
  endtask

  task automatic t_busy_ignore();
    int r0; bit ok;
    lat_extra = 1;
    cfg_write(2'd0, 32'd16);
    cfg_write(2'd1, 32'd2);
    cfg_write(2'd2, 32'd5);
    cfg_write(2'd3, 32'd3);
    r0 = nreads;
    pulse_start();
    @(negedge clk);
    start = 1'b1;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 32'd99;
    @(negedge clk);
    start = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_data = 32'd7;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_done(ok);
    chk(nreads - r0 == 5, "R7", "restart during run ignored (reads)", 32'(nreads - r0), 5);
    chk(result == model_sum(8'd16, 8'd2, 5, 32'd3), "R7", "loop unaffected by busy writes",
        result, model_sum(8'd16, 8'd2, 5, 32'd3));
    r0 = nreads;
    pulse_start();
    wait_done(ok);
    chk(addr_log[r0 % 4096] == 8'd16, "R7", "stored start address kept",
        32'(addr_log[r0 % 4096]), 16);
    chk(result == model_sum(8'd16, 8'd2, 5, 32'd3), "R7", "stored multiplier kept",
        result, model_sum(8'd16, 8'd2, 5, 32'd3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_loop(8'd0,   8'd1, 8,  32'd2,        0, "R4 unit stride x2");
    run_loop(8'd7,   8'd3, 5,  32'hFFFF_FFFF, 0, "R4 wrapping multiplier");
    run_loop(8'd250, 8'd4, 6,  32'd5,        0, "R2 address wrap");
    run_loop(8'd40,  8'd1, 4,  32'd11,       3, "R6 slow memory");
    run_loop(8'd3,   8'd9, 63, 32'd13,       0, "R3 largest count");
    run_loop(8'd100, 8'd0, 3,  32'd1,        2, "R9 zero step");
    t_zero_count();
    t_done_hold();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule